// File: doc/BRIEF.md
# Pin-Resolving GPIO Register Bank

This block is a bank of general-purpose pins controlled through a 32-bit register interface. Each pin has its own bit in several control registers: output value, output enable, open-drain type, pull-up, pull-down, polarity and input enable. From these controls and an external drive input, the block works out the level on every pad. It returns that level on a pin-state output. It also returns it, masked and re-inverted, through the data-in register.

Software can change individual output or enable bits without a read-modify-write, using set and clear aliases. A temporary lock protects the configuration. Any write to either lock word engages the lock. Only a two-word key sequence, written with no other access between the two words, releases it. Reset values are parameters, so that sibling instances can come up in different states.

A bus access lasts one cycle and is marked by `bus_sel`. A write takes effect at the clock edge that ends the access. Read data is combinational from the address.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset the configuration registers hold the reset-value parameters and the lock word reads 0. Register offsets are: lock word A 0x00, data-in 0x04, polarity 0x08, output value 0x0C, output enable 0x10, open-drain type 0x14, pull-up 0x1C, pull-down 0x20, input enable 0x58, output set 0x68, output clear 0x6C, enable set 0x70, enable clear 0x74, lock word B 0x7C.
- R2: A pin with output enable 1 and type bit 0 (push-pull) is driven to output XOR polarity. For such a pin, data-in equals the output bit whatever the pulls and the polarity are.
- R3: A pin that no driver drives takes its pull-up bit as its level. The output bit and the type bit then have no effect.
- R4: With output enable 1 and type bit 1 (open drain), an effective output (output XOR polarity) of 0 drives the pin low. An effective output of 1 leaves the pin undriven.
- R5: Data-in bit = (pin level AND input-enable bit) XOR polarity bit.
- R6: An input-enable bit of 0 forces that pin's input to 0 before polarity is applied.
- R7: A write to a set alias ORs the written 1 bits into the output register or the enable register. A write to a clear alias clears them. Bits written as 0 keep their value, and the aliases read as 0.
- R8: A write of any value to lock word A or lock word B engages the lock. While the lock is engaged, lock word A reads 1.
- R9: While the lock is engaged, writes to polarity, output, enable, type, pull-up, pull-down, input-enable and the four aliases are ignored.
- R10: The lock is released by writing 0xC0DE1248 to lock word B and then 0xC0DEFA73 to lock word A on the very next access. Lock word A then reads 0 and writes take effect again.
- R11: If any other access comes between the two key writes, or either key value is wrong, the block stays locked.
- R12: A pin not driven from inside takes the external value when its external drive flag is 1, overriding the pulls. The internal driver wins over the external drive. The level of every pin is presented on `pin_state`.
- R13: Writes to the data-in offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_drv_en | input | NPIN | Per pin: the external source is driving |
| ext_drv_val | input | NPIN | Per pin: external drive level |
| pin_state | output | NPIN | Resolved pad level per pin |

## Verification
The central pattern is a sweep over all 512 combinations of the seven per-pin control bits and the two external drive bits. Thirty-two combinations are packed into each register write, so every resolution path is separated from every other: push-pull, open-drain low, open-drain release, pull, and external override. Fixed word patterns with mixed bits then check polarity cancellation, the effect of input masking and the arithmetic of the aliases. Lock sequences are tried both intact and broken: by an intervening read, by a wrong first key and by a wrong second key. This tells apart a design that counts key writes from one that really requires two adjacent writes.

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank #(
  parameter int unsigned NPIN       = 32,
  parameter logic [31:0] RST_POL    = 32'h0,
  parameter logic [31:0] RST_DOUT   = 32'h0,
  parameter logic [31:0] RST_OE     = 32'h0,
  parameter logic [31:0] RST_OTYP   = 32'h0,
  parameter logic [31:0] RST_PU     = 32'h0,
  parameter logic [31:0] RST_PD     = 32'h0,
  parameter logic [31:0] RST_IEM    = 32'hFFFF_FFFF,
  parameter logic [31:0] KEY_FIRST  = 32'hC0DE_1248,
  parameter logic [31:0] KEY_SECOND = 32'hC0DE_FA73
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [6:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] ext_drv_en,
  input  logic [NPIN-1:0] ext_drv_val,
  output logic [NPIN-1:0] pin_state
);
  localparam logic [6:0] A_LOCKA = 7'h00, A_DIN  = 7'h04, A_POL  = 7'h08, A_DOUT = 7'h0C;
  localparam logic [6:0] A_OE    = 7'h10, A_OTYP = 7'h14, A_PU   = 7'h1C, A_PD   = 7'h20;
  localparam logic [6:0] A_IEM   = 7'h58, A_DOS  = 7'h68, A_DOC  = 7'h6C, A_OES  = 7'h70;
  localparam logic [6:0] A_OEC   = 7'h74, A_LOCKB = 7'h7C;

  logic [NPIN-1:0] pol, dout, oe, otyp, pu, pd, iem;
  logic [NPIN-1:0] eff, drv, din;
  logic            locked, armed;

  wire             wr_any = bus_sel & bus_wr;
  wire             cfg_we = wr_any & ~locked;
  wire [NPIN-1:0]  wd     = bus_wdata[NPIN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol  <= RST_POL[NPIN-1:0];
      dout <= RST_DOUT[NPIN-1:0];
      oe   <= RST_OE[NPIN-1:0];
      otyp <= RST_OTYP[NPIN-1:0];
      pu   <= RST_PU[NPIN-1:0];
      pd   <= RST_PD[NPIN-1:0];
      iem  <= RST_IEM[NPIN-1:0];
    end else if (cfg_we) begin
      case (bus_addr)
        A_POL:   pol  <= wd;
        A_DOUT:  dout <= wd;
        A_OE:    oe   <= wd;
        A_OTYP:  otyp <= wd;
        A_PU:    pu   <= wd;
        A_PD:    pd   <= wd;
        A_IEM:   iem  <= wd;
        A_DOS:   dout <= dout | wd;
        A_DOC:   dout <= dout & ~wd;
        A_OES:   oe   <= oe | wd;
        A_OEC:   oe   <= oe & ~wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end else if (bus_sel) begin
      armed <= 1'b0;
      if (bus_wr && bus_addr == A_LOCKB) begin
        locked <= 1'b1;
        armed  <= (bus_wdata == KEY_FIRST);
      end else if (bus_wr && bus_addr == A_LOCKA) begin
        locked <= ~(armed && bus_wdata == KEY_SECOND);
      end
    end
  end

  assign eff       = dout ^ pol;
  assign drv       = oe & (~otyp | ~eff);
  assign pin_state = (drv & eff) | (~drv & ext_drv_en & ext_drv_val) | (~drv & ~ext_drv_en & pu);
  assign din       = (pin_state & iem) ^ pol;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOCKA: bus_rdata[0]      = locked;
      A_DIN:   bus_rdata[NPIN-1:0] = din;
      A_POL:   bus_rdata[NPIN-1:0] = pol;
      A_DOUT:  bus_rdata[NPIN-1:0] = dout;
      A_OE:    bus_rdata[NPIN-1:0] = oe;
      A_OTYP:  bus_rdata[NPIN-1:0] = otyp;
      A_PU:    bus_rdata[NPIN-1:0] = pu;
      A_PD:    bus_rdata[NPIN-1:0] = pd;
      A_IEM:   bus_rdata[NPIN-1:0] = iem;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int unsigned NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [6:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic            locked,
  input logic            armed,
  input logic [NPIN-1:0] dout,
  input logic [NPIN-1:0] oe,
  input logic [NPIN-1:0] otyp,
  input logic [NPIN-1:0] pol,
  input logic [NPIN-1:0] pin_state
);
  // R2: push-pull pins follow the effective output on the pad
  a_r2_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_state ^ (dout ^ pol)) & oe & ~otyp) == '0);

  // R4: open-drain pins with effective output 0 sit low
  a_r4_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_state & oe & otyp & ~(dout ^ pol)) == '0);

  a_r8_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 7'h00) |-> bus_rdata == {31'b0, locked});

  a_r9_locked_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_sel && bus_wr && bus_addr == 7'h0C) |=> dout == $past(dout));

  a_r7_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_sel && bus_wr && bus_addr == 7'h68) |=>
      dout == ($past(dout) | $past(bus_wdata[NPIN-1:0])));

  a_r7_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_sel && bus_wr && bus_addr == 7'h74) |=>
      oe == ($past(oe) & ~$past(bus_wdata[NPIN-1:0])));

  a_r10_unlock_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(armed));
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NPIN(NPIN)) u_chk (.*);

// File: tb/sim_gpio_pad_bank.sv
`timescale 1ns/1ps
module sim_gpio_pad_bank;
  localparam logic [31:0] PU_RST = 32'h1234_5678;
  localparam logic [6:0] A_LOCKA = 7'h00, A_DIN = 7'h04, A_POL = 7'h08, A_DOUT = 7'h0C;
  localparam logic [6:0] A_OE = 7'h10, A_OTYP = 7'h14, A_PU = 7'h1C, A_PD = 7'h20;
  localparam logic [6:0] A_IEM = 7'h58, A_DOS = 7'h68, A_DOC = 7'h6C, A_OES = 7'h70;
  localparam logic [6:0] A_OEC = 7'h74, A_LOCKB = 7'h7C;
  localparam logic [31:0] K1 = 32'hC0DE_1248, K2 = 32'hC0DE_FA73;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] ext_en = '0, ext_val = '0, pin_state;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_pad_bank #(.NPIN(32), .RST_PU(PU_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_drv_en(ext_en),
    .ext_drv_val(ext_val), .pin_state(pin_state));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rdchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  function automatic logic [31:0] pad(input logic [31:0] d, oe, ot, pu, pol, xe, xv);
    logic [31:0] p;
    for (int i = 0; i < 32; i++) begin
      logic e;
      e = d[i] ^ pol[i];
      if (oe[i] && (!ot[i] || !e)) p[i] = e;
      else if (xe[i]) p[i] = xv[i];
      else p[i] = pu[i];
    end
    return p;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rdchk("R1 lock", A_LOCKA, 32'h0);
    rdchk("R1 pu", A_PU, PU_RST);
    rdchk("R1 iem", A_IEM, 32'hFFFF_FFFF);
    rdchk("R1 dout", A_DOUT, 32'h0);

    // R2 R3 R4 R5 R6 R12 sweep over all 512 per-pin combinations
    for (int r = 0; r < 16; r++) begin
      logic [31:0] d, o, t, u, n, p, m, xe, xv, exp_pin;
      for (int b = 0; b < 32; b++) begin
        int c;
        c = r * 32 + b;
        d[b] = c[0]; o[b] = c[1]; t[b] = c[2]; u[b] = c[3]; n[b] = c[4];
        p[b] = c[5]; m[b] = c[6]; xe[b] = c[7]; xv[b] = c[8];
      end
      wr(A_DOUT, d); wr(A_OE, o); wr(A_OTYP, t); wr(A_PU, u);
      wr(A_PD, n); wr(A_POL, p); wr(A_IEM, m);
      @(negedge clk); ext_en = xe; ext_val = xv;
      exp_pin = pad(d, o, t, u, p, xe, xv);
      #1 check("R12 sweep pin_state", pin_state, exp_pin);
      rdchk("R5 R6 sweep din", A_DIN, (exp_pin & m) ^ p);
    end
    @(negedge clk); ext_en = '0; ext_val = '0;

    // R6 masked input example
    wr(A_OTYP, 0); wr(A_OE, 32'hFFFF_FFFF); wr(A_DOUT, 32'hFF00_FF00);
    wr(A_POL, 32'hFFFF_0000); wr(A_IEM, 32'h8765_4321);
    rdchk("R6 mask", A_DIN, 32'hFF9A_4300);

    // R2 polarity cancels in push-pull
    wr(A_IEM, 32'hFFFF_FFFF); wr(A_DOUT, 32'h5678_9ABC); wr(A_POL, 32'h6789_ABCD);
    wr(A_PU, 32'h0F0F_0F0F); wr(A_PD, 32'hF0F0_F0F0);
    rdchk("R2 din=dout", A_DIN, 32'h5678_9ABC);

    // R3 undriven follows pull-up, dout ignored
    wr(A_POL, 0); wr(A_OE, 0); wr(A_DOUT, 32'hFFFF_0000);
    wr(A_PU, 32'h2345_6789); wr(A_PD, ~32'h2345_6789);
    rdchk("R3 pull", A_DIN, 32'h2345_6789);

    // R4 open-drain mixture
    wr(A_OTYP, 32'h4567_89AB); wr(A_OE, 32'hF0F0_F0F0); wr(A_DOUT, 32'hFFFF_0000);
    wr(A_PU, 32'hFF00_FF00); wr(A_PD, 32'h00FF_00FF);
    rdchk("R4 open drain", A_DIN, 32'hFF90_0F00);

    // R12 external drive vs internal drive
    wr(A_OTYP, 0); wr(A_OE, 32'h0000_FFFF); wr(A_DOUT, 0); wr(A_PU, 32'hFFFF_FFFF);
    @(negedge clk); ext_en = 32'hFFFF_FFFF; ext_val = 32'hA5A5_F0F0;
    rdchk("R12 override", A_DIN, 32'hA5A5_0000);
    @(negedge clk); ext_en = '0; ext_val = '0;

    // R7 aliases
    wr(A_OE, 32'h3456_789A); wr(A_OEC, 32'h0003_0002);
    rdchk("R7 oe clear", A_OE, 32'h3454_7898);
    wr(A_OES, 32'h0000_F001);
    rdchk("R7 oe set", A_OE, 32'h3454_F899);
    wr(A_DOUT, 32'h0000_00F0); wr(A_DOS, 32'h8000_0001); wr(A_DOC, 32'h0000_0030);
    rdchk("R7 dout set/clear", A_DOUT, 32'h8000_00C1);
    rdchk("R7 alias reads 0", A_DOS, 32'h0);

    // R13 data-in is read-only
    wr(A_OE, 32'hFFFF_FFFF); wr(A_DOUT, 32'h1357_9BDF); wr(A_DIN, 32'h0);
    rdchk("R13 din write ignored", A_DIN, 32'h1357_9BDF);

    // R8 R9 lock
    wr(A_LOCKA, 32'h0);
    rdchk("R8 locked by A", A_LOCKA, 32'h1);
    wr(A_DOUT, 32'hA987_6543); wr(A_DOS, 32'hFFFF_FFFF);
    rdchk("R9 dout held", A_DOUT, 32'h1357_9BDF);
    wr(A_POL, 32'hFFFF_FFFF); wr(A_OEC, 32'hFFFF_FFFF); wr(A_IEM, 32'h0);
    rdchk("R9 pol held", A_POL, 32'h0);
    rdchk("R9 oe held", A_OE, 32'hFFFF_FFFF);
    rdchk("R9 iem held", A_IEM, 32'hFFFF_FFFF);

    // R11 broken sequences
    wr(A_LOCKB, K1); rd(A_DIN, v); wr(A_LOCKA, K2);
    rdchk("R11 interrupted", A_LOCKA, 32'h1);
    wr(A_LOCKB, K1); wr(A_LOCKA, K1);
    rdchk("R11 wrong second key", A_LOCKA, 32'h1);
    wr(A_LOCKB, K2); wr(A_LOCKA, K2);
    rdchk("R11 wrong first key", A_LOCKA, 32'h1);

    // R10 unlock
    wr(A_LOCKB, K1); wr(A_LOCKA, K2);
    rdchk("R10 unlocked", A_LOCKA, 32'h0);
    wr(A_DOUT, 32'hA987_6543);
    rdchk("R10 write effective", A_DOUT, 32'hA987_6543);

    // R8 lock via B
    wr(A_LOCKB, 32'h0);
    rdchk("R8 locked by B", A_LOCKA, 32'h1);
    wr(A_DOUT, 32'h0);
    rdchk("R9 dout held after B", A_DOUT, 32'hA987_6543);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule